// File: doc/BRIEF.md
# Combo Display PHY Power-Up Sequencer

This block brings a two-mode display PHY out of power-down and puts it back. It works only through a register-write bus. Each register update is a read of the target register followed by a write that changes only the masked bits. The updates are issued in a fixed order, and timed waits counted on a microsecond tick are placed between them where a reset pulse or an analog settle time is needed. One power-on request starts the bring-up that matches the selected mode: either the high-speed serial-lane mode or the LVDS mode. One power-off request starts the shutdown sequence.

Every PHY register is named by a 3-bit partition and a 5-bit offset. The partitions are analog, digital, one clock lane, four data lanes and the LVDS section. The sequencer latches the divider values when it accepts a request. It holds `busy` while a sequence runs and gives a one-cycle `done` at the end. When the mode select is unsupported, that `done` comes with `err`.

Top module: `physeq_top`

## Requirements
- R1: The bus byte address is `{partition[2:0], offset[4:0], 2'b00}`. Partition numbers: analog 0, digital 1, clock lane 2, data lanes 3 to 6, LVDS 7. For example, LVDS offset 3 is byte address 0x38C.
- R2: Every update reads the register first. It then writes `(old & ~mask) | (data & mask)` to the same address. Bits outside the mask keep the value that was read.
- R3: Both power-on sequences begin with the same two updates to analog register 0. The first clears bit 7 (bandgap power-down). The second writes 2'b01 into bits [1:0] (work enable).
- R4: Serial-lane mode (`mode_sel`=0) then performs these updates in order:
  - LVDS register 3 bits [2:0] = 3'b001.
  - Analog register 3 bits [4:0] = prediv.
  - Analog register 3 bit 5 = fbdiv[8].
  - Analog register 4 = fbdiv[7:0].
  - Clear analog register 1 bits [1:0] (LDO and PLL power-down).
  - Analog register 1 bit 2 set, wait, bit 2 cleared.
  - Digital register 0 bit 0 cleared, wait, bit 0 set.
  - Set analog register 0 bits [6:2] (lane enables).
- R5: Each reset pulse spans at least `RESET_US` microsecond ticks, counted from the update that asserts it to the update that releases it.
- R6: LVDS mode (`mode_sel`=1) then performs these updates in order:
  - Analog register 8 bit 4 = 1.
  - LVDS register 3 bits [2:0] = 3'b010.
  - Analog register 3 bits [4:0] = 2.
  - Analog register 3 bit 5 = 0.
  - Analog register 4 = 28.
  - LVDS register 8 = 0xFC.
  - Clear LVDS register 11 bits 2 and 0 (PLL and bandgap power).
  - Wait, then LVDS register 0 bit 2 cleared, wait, bit 2 set.
  - LVDS register 1 bit 7 set.
  - LVDS register 11 bits [7:3] set.
- R7: In LVDS mode, at least `SETTLE_US` ticks pass between powering the LVDS PLL and bandgap and the start of the internal reset pulse.
- R8: Power-off performs these updates in order:
  - Clear analog register 0 bits [6:2].
  - Set analog register 1 bits [1:0].
  - Write 2'b10 into analog register 0 bits [1:0].
  - Set analog register 0 bit 7.
  - Clear LVDS register 11 bits [7:3].
  - Clear LVDS register 1 bit 7.
  - Set LVDS register 11 bits 2 and 0.
- R9: A power-on request with `mode_sel` of 2 or 3 gives `done` together with `err` and makes no bus request.
- R10: `busy` stays high from acceptance to completion. `done` is a single-cycle pulse with `busy` low. Requests that arrive while `busy` is high are ignored. When both requests arrive in the same cycle, power-on wins.
- R11: There is at most one outstanding bus request. `bus_req`, `bus_we`, `bus_addr` and `bus_wdata` stay stable until `bus_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | 0 serial-lane, 1 LVDS, others unsupported |
| pwr_on_req | input | 1 | Start power-on sequence (one-cycle request) |
| pwr_off_req | input | 1 | Start power-off sequence (one-cycle request) |
| prediv_in | input | 5 | Serial-mode PLL pre-divider |
| fbdiv_in | input | 9 | Serial-mode PLL feedback divider |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| bus_req | output | 1 | Bus request valid |
| bus_we | output | 1 | 1 write, 0 read |
| bus_addr | output | 10 | Byte address |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid with bus_ready on a read |
| bus_ready | input | 1 | Request accepted or completed |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | With done: unsupported mode |

## Verification
The bench builds the block with `RESET_US`=3 and `SETTLE_US`=40. With those values the 20 ms-class settle wait and the reset pulses take only a few hundred cycles, so every sequence runs to completion many times. The tick interval is five cycles, which makes the counted gaps long enough to tell a shortened wait apart from a correct one. The register model starts with random contents and answers with random latency. Because of that, mask handling and request holding are exercised against arbitrary old values and stalls.

// File: rtl/physeq_pkg.sv
package physeq_pkg;
  localparam int PART_W = 3;
  localparam int OFF_W  = 5;
  localparam int REG_W  = 8;
  localparam int RADDR_W = PART_W + OFF_W;
  localparam int BUS_AW  = RADDR_W + 2;

  localparam logic [PART_W-1:0] P_ANA  = 3'd0;
  localparam logic [PART_W-1:0] P_DIG  = 3'd1;
  localparam logic [PART_W-1:0] P_LVDS = 3'd7;

  typedef enum logic [1:0] {SEQ_SERIAL, SEQ_LVDS, SEQ_OFF} seq_e;
  typedef enum logic [1:0] {OP_END, OP_RMW, OP_WAIT_RST, OP_WAIT_SETTLE} op_e;
  typedef enum logic [1:0] {T_IDLE, T_STEP, T_RMW, T_TMR} top_st_e;
  typedef enum logic [1:0] {B_IDLE, B_RD, B_WR} bus_st_e;

  typedef struct packed {
    op_e               op;
    logic [PART_W-1:0] part;
    logic [OFF_W-1:0]  off;
    logic [REG_W-1:0]  mask;
    logic [REG_W-1:0]  data;
  } step_t;

  function automatic step_t mk(op_e op, logic [PART_W-1:0] part,
                               logic [OFF_W-1:0] off, logic [REG_W-1:0] mask,
                               logic [REG_W-1:0] data);
    step_t s;
    s.op = op; s.part = part; s.off = off; s.mask = mask; s.data = data;
    return s;
  endfunction
endpackage

// File: rtl/physeq_steps.sv
module physeq_steps
  import physeq_pkg::*;
#(
  parameter int IDX_W = 5,
  parameter int LVDS_PREDIV = 2,
  parameter int LVDS_FBDIV  = 28
) (
  input  seq_e             seq,
  input  logic [IDX_W-1:0] idx,
  input  logic [4:0]       prediv,
  input  logic [8:0]       fbdiv,
  output step_t            step
);
  localparam logic [8:0] LV_FB = 9'(LVDS_FBDIV);
  localparam logic [4:0] LV_PD = 5'(LVDS_PREDIV);

  always_comb begin
    step = mk(OP_END, '0, '0, '0, '0);
    if (idx == IDX_W'(0) && seq != SEQ_OFF)
      step = mk(OP_RMW, P_ANA, 5'd0, 8'h80, 8'h00);
    else if (idx == IDX_W'(1) && seq != SEQ_OFF)
      step = mk(OP_RMW, P_ANA, 5'd0, 8'h03, 8'h01);
    else begin
      case (seq)
        SEQ_SERIAL: begin
          case (idx)
            IDX_W'(2):  step = mk(OP_RMW, P_LVDS, 5'd3, 8'h07, 8'h01);
            IDX_W'(3):  step = mk(OP_RMW, P_ANA, 5'd3, 8'h1F, {3'b000, prediv});
            IDX_W'(4):  step = mk(OP_RMW, P_ANA, 5'd3, 8'h20, {2'b00, fbdiv[8], 5'b0});
            IDX_W'(5):  step = mk(OP_RMW, P_ANA, 5'd4, 8'hFF, fbdiv[7:0]);
            IDX_W'(6):  step = mk(OP_RMW, P_ANA, 5'd1, 8'h03, 8'h00);
            IDX_W'(7):  step = mk(OP_RMW, P_ANA, 5'd1, 8'h04, 8'h04);
            IDX_W'(8):  step = mk(OP_WAIT_RST, '0, '0, '0, '0);
            IDX_W'(9):  step = mk(OP_RMW, P_ANA, 5'd1, 8'h04, 8'h00);
            IDX_W'(10): step = mk(OP_RMW, P_DIG, 5'd0, 8'h01, 8'h00);
            IDX_W'(11): step = mk(OP_WAIT_RST, '0, '0, '0, '0);
            IDX_W'(12): step = mk(OP_RMW, P_DIG, 5'd0, 8'h01, 8'h01);
            IDX_W'(13): step = mk(OP_RMW, P_ANA, 5'd0, 8'h7C, 8'h7C);
            default:    step = mk(OP_END, '0, '0, '0, '0);
          endcase
        end
        SEQ_LVDS: begin
          case (idx)
            IDX_W'(2):  step = mk(OP_RMW, P_ANA, 5'd8, 8'h10, 8'h10);
            IDX_W'(3):  step = mk(OP_RMW, P_LVDS, 5'd3, 8'h07, 8'h02);
            IDX_W'(4):  step = mk(OP_RMW, P_ANA, 5'd3, 8'h1F, {3'b000, LV_PD});
            IDX_W'(5):  step = mk(OP_RMW, P_ANA, 5'd3, 8'h20, {2'b00, LV_FB[8], 5'b0});
            IDX_W'(6):  step = mk(OP_RMW, P_ANA, 5'd4, 8'hFF, LV_FB[7:0]);
            IDX_W'(7):  step = mk(OP_RMW, P_LVDS, 5'd8, 8'hFF, 8'hFC);
            IDX_W'(8):  step = mk(OP_RMW, P_LVDS, 5'd11, 8'h05, 8'h00);
            IDX_W'(9):  step = mk(OP_WAIT_SETTLE, '0, '0, '0, '0);
            IDX_W'(10): step = mk(OP_RMW, P_LVDS, 5'd0, 8'h04, 8'h00);
            IDX_W'(11): step = mk(OP_WAIT_RST, '0, '0, '0, '0);
            IDX_W'(12): step = mk(OP_RMW, P_LVDS, 5'd0, 8'h04, 8'h04);
            IDX_W'(13): step = mk(OP_RMW, P_LVDS, 5'd1, 8'h80, 8'h80);
            IDX_W'(14): step = mk(OP_RMW, P_LVDS, 5'd11, 8'hF8, 8'hF8);
            default:    step = mk(OP_END, '0, '0, '0, '0);
          endcase
        end
        default: begin
          case (idx)
            IDX_W'(0): step = mk(OP_RMW, P_ANA, 5'd0, 8'h7C, 8'h00);
            IDX_W'(1): step = mk(OP_RMW, P_ANA, 5'd1, 8'h03, 8'h03);
            IDX_W'(2): step = mk(OP_RMW, P_ANA, 5'd0, 8'h03, 8'h02);
            IDX_W'(3): step = mk(OP_RMW, P_ANA, 5'd0, 8'h80, 8'h80);
            IDX_W'(4): step = mk(OP_RMW, P_LVDS, 5'd11, 8'hF8, 8'h00);
            IDX_W'(5): step = mk(OP_RMW, P_LVDS, 5'd1, 8'h80, 8'h00);
            IDX_W'(6): step = mk(OP_RMW, P_LVDS, 5'd11, 8'h05, 8'h05);
            default:   step = mk(OP_END, '0, '0, '0, '0);
          endcase
        end
      endcase
    end
  end
endmodule

// File: rtl/physeq_rmw.sv
module physeq_rmw
  import physeq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [PART_W-1:0] part,
  input  logic [OFF_W-1:0]  off,
  input  logic [REG_W-1:0]  mask,
  input  logic [REG_W-1:0]  data,
  output logic              fin,
  output logic              bus_req,
  output logic              bus_we,
  output logic [BUS_AW-1:0] bus_addr,
  output logic [REG_W-1:0]  bus_wdata,
  input  logic [REG_W-1:0]  bus_rdata,
  input  logic              bus_ready
);
  bus_st_e          st;
  logic [REG_W-1:0] mask_q, data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= B_IDLE;
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      mask_q    <= '0;
      data_q    <= '0;
      fin       <= 1'b0;
    end else begin
      fin <= 1'b0;
      case (st)
        B_IDLE: if (start) begin
          bus_addr <= {part, off, 2'b00};
          mask_q   <= mask;
          data_q   <= data;
          bus_we   <= 1'b0;
          bus_req  <= 1'b1;
          st       <= B_RD;
        end
        B_RD: if (bus_ready) begin
          bus_wdata <= (bus_rdata & ~mask_q) | (data_q & mask_q);
          bus_we    <= 1'b1;
          st        <= B_WR;
        end
        B_WR: if (bus_ready) begin
          bus_req <= 1'b0;
          bus_we  <= 1'b0;
          fin     <= 1'b1;
          st      <= B_IDLE;
        end
        default: st <= B_IDLE;
      endcase
    end
  end

  // R11: a pending request is held unchanged until accepted
  a_r11_req_hold: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_ready) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));
  // R2: an accepted read is followed by a write to the same address
  a_r2_write_follows_read: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_ready && !bus_we) |=> (bus_req && bus_we && $stable(bus_addr)));
  // R1: byte address is word aligned
  a_r1_aligned: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> (bus_addr[1:0] == 2'b00));
endmodule

// File: rtl/physeq_wait.sv
module physeq_wait #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] load,
  input  logic             tick,
  output logic             fin
);
  logic [CNT_W-1:0] cnt;
  logic             active;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      active <= 1'b0;
      fin    <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (start) begin
        cnt    <= load;
        active <= 1'b1;
      end else if (active) begin
        if (cnt == '0) begin
          active <= 1'b0;
          fin    <= 1'b1;
        end else if (tick) begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  // R5 / R7: the wait cannot finish while ticks remain outstanding
  a_r5_no_early_finish: assert property (@(posedge clk) disable iff (rst)
    (active && cnt != '0) |=> !fin);
  a_r7_count_only_on_tick: assert property (@(posedge clk) disable iff (rst)
    (active && !tick && !start) |=> (cnt == $past(cnt)));
endmodule

// File: rtl/physeq_top.sv
module physeq_top
  import physeq_pkg::*;
#(
  parameter int RESET_US  = 1,
  parameter int SETTLE_US = 20000,
  parameter int IDX_W     = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode_sel,
  input  logic              pwr_on_req,
  input  logic              pwr_off_req,
  input  logic [4:0]        prediv_in,
  input  logic [8:0]        fbdiv_in,
  input  logic              us_tick,
  output logic              bus_req,
  output logic              bus_we,
  output logic [BUS_AW-1:0] bus_addr,
  output logic [REG_W-1:0]  bus_wdata,
  input  logic [REG_W-1:0]  bus_rdata,
  input  logic              bus_ready,
  output logic              busy,
  output logic              done,
  output logic              err
);
  localparam int MAX_US = (SETTLE_US > RESET_US) ? SETTLE_US : RESET_US;
  localparam int CNT_W  = $clog2(MAX_US + 1);
  localparam logic [CNT_W-1:0] RST_LOAD    = CNT_W'(RESET_US);
  localparam logic [CNT_W-1:0] SETTLE_LOAD = CNT_W'(SETTLE_US);

  top_st_e          st;
  seq_e             seq;
  logic [IDX_W-1:0] idx;
  logic [4:0]       prediv_q;
  logic [8:0]       fbdiv_q;
  step_t            step;
  logic             rmw_start, rmw_fin;
  logic             tmr_start, tmr_fin;
  logic [CNT_W-1:0] tmr_load;

  physeq_steps #(.IDX_W(IDX_W)) steps_i (
    .seq(seq), .idx(idx), .prediv(prediv_q), .fbdiv(fbdiv_q), .step(step)
  );

  physeq_rmw rmw_i (
    .clk(clk), .rst(rst), .start(rmw_start),
    .part(step.part), .off(step.off), .mask(step.mask), .data(step.data),
    .fin(rmw_fin), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready)
  );

  physeq_wait #(.CNT_W(CNT_W)) wait_i (
    .clk(clk), .rst(rst), .start(tmr_start), .load(tmr_load),
    .tick(us_tick), .fin(tmr_fin)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= T_IDLE;
      seq       <= SEQ_SERIAL;
      idx       <= '0;
      prediv_q  <= '0;
      fbdiv_q   <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
      rmw_start <= 1'b0;
      tmr_start <= 1'b0;
      tmr_load  <= '0;
    end else begin
      done      <= 1'b0;
      err       <= 1'b0;
      rmw_start <= 1'b0;
      tmr_start <= 1'b0;
      case (st)
        T_IDLE: begin
          idx      <= '0;
          prediv_q <= prediv_in;
          fbdiv_q  <= fbdiv_in;
          if (pwr_on_req) begin
            if (mode_sel == 2'd0 || mode_sel == 2'd1) begin
              seq  <= (mode_sel == 2'd0) ? SEQ_SERIAL : SEQ_LVDS;
              busy <= 1'b1;
              st   <= T_STEP;
            end else begin
              done <= 1'b1;
              err  <= 1'b1;
            end
          end else if (pwr_off_req) begin
            seq  <= SEQ_OFF;
            busy <= 1'b1;
            st   <= T_STEP;
          end
        end
        T_STEP: begin
          case (step.op)
            OP_RMW: begin
              rmw_start <= 1'b1;
              st        <= T_RMW;
            end
            OP_WAIT_RST, OP_WAIT_SETTLE: begin
              tmr_load  <= (step.op == OP_WAIT_SETTLE) ? SETTLE_LOAD : RST_LOAD;
              tmr_start <= 1'b1;
              st        <= T_TMR;
            end
            default: begin
              busy <= 1'b0;
              done <= 1'b1;
              st   <= T_IDLE;
            end
          endcase
        end
        T_RMW: if (rmw_fin) begin
          idx <= idx + 1'b1;
          st  <= T_STEP;
        end
        T_TMR: if (tmr_fin) begin
          idx <= idx + 1'b1;
          st  <= T_STEP;
        end
        default: st <= T_IDLE;
      endcase
    end
  end

  // R10: completion is a single-cycle pulse outside the busy window
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r10_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  a_r10_no_bus_when_idle: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !bus_req);
  // R9: the error flag only appears on completion
  a_r9_err_with_done: assert property (@(posedge clk) disable iff (rst)
    err |-> done);
endmodule

// File: tb/physeq_top_tb_top.sv
module physeq_top_tb_top;
  localparam int RST_US = 3;
  localparam int SET_US = 40;

  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] mode_sel;
  logic       pwr_on_req, pwr_off_req;
  logic [4:0] prediv_in;
  logic [8:0] fbdiv_in;
  logic       us_tick;
  logic       bus_req, bus_we, bus_ready;
  logic [9:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic       busy, done, err;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  physeq_top #(.RESET_US(RST_US), .SETTLE_US(SET_US)) dut_i (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .pwr_on_req(pwr_on_req),
    .pwr_off_req(pwr_off_req), .prediv_in(prediv_in), .fbdiv_in(fbdiv_in),
    .us_tick(us_tick), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
    .busy(busy), .done(done), .err(err)
  );

  // microsecond tick every 5 cycles and a running tick count
  int tdiv = 0;
  int tick_cnt = 0;
  always @(posedge clk) begin
    tdiv     <= (tdiv == 4) ? 0 : tdiv + 1;
    us_tick  <= (tdiv == 4);
    tick_cnt <= tick_cnt + (us_tick ? 1 : 0);
  end

  // register model with random response latency and a write log
  logic [7:0] mem [256];
  logic [7:0] shadow [256];
  int log_n = 0;
  int log_addr [64];
  int log_raw  [64];
  int log_val  [64];
  int log_tick [64];
  int dly = 0;

  initial bus_ready = 1'b0;
  initial bus_rdata = 8'h00;
  always @(posedge clk) begin
    if (bus_ready) begin
      bus_ready <= 1'b0;
    end else if (bus_req) begin
      if (dly == 0) begin
        bus_ready <= 1'b1;
        bus_rdata <= mem[bus_addr[9:2]];
        dly       <= int'($urandom_range(3, 0));
        if (bus_we) begin
          mem[bus_addr[9:2]] <= bus_wdata;
          if (log_n < 64) begin
            log_addr[log_n] <= int'(bus_addr[9:2]);
            log_raw[log_n]  <= int'(bus_addr);
            log_val[log_n]  <= int'(bus_wdata);
            log_tick[log_n] <= tick_cnt;
          end
          log_n <= log_n + 1;
        end
      end else begin
        dly <= dly - 1;
      end
    end
  end

  // expected step: {kind[1:0], reg addr[7:0], mask, data}; kind 0 end, 1 update, 2 reset wait, 3 settle wait
  function automatic logic [25:0] e(int k, int a, int m, int d);
    return {2'(k), 8'(a), 8'(m), 8'(d)};
  endfunction

  function automatic logic [25:0] exp_step(int seq, int i, logic [4:0] pd, logic [8:0] fb);
    if (seq != 2 && i == 0) return e(1, 8'h00, 8'h80, 8'h00);
    if (seq != 2 && i == 1) return e(1, 8'h00, 8'h03, 8'h01);
    if (seq == 0) begin
      case (i)
        2: return e(1, 8'hE3, 8'h07, 8'h01);
        3: return e(1, 8'h03, 8'h1F, int'(pd));
        4: return e(1, 8'h03, 8'h20, fb[8] ? 8'h20 : 8'h00);
        5: return e(1, 8'h04, 8'hFF, int'(fb[7:0]));
        6: return e(1, 8'h01, 8'h03, 8'h00);
        7: return e(1, 8'h01, 8'h04, 8'h04);
        8: return e(2, 0, 0, 0);
        9: return e(1, 8'h01, 8'h04, 8'h00);
        10: return e(1, 8'h20, 8'h01, 8'h00);
        11: return e(2, 0, 0, 0);
        12: return e(1, 8'h20, 8'h01, 8'h01);
        13: return e(1, 8'h00, 8'h7C, 8'h7C);
        default: return e(0, 0, 0, 0);
      endcase
    end else if (seq == 1) begin
      case (i)
        2: return e(1, 8'h08, 8'h10, 8'h10);
        3: return e(1, 8'hE3, 8'h07, 8'h02);
        4: return e(1, 8'h03, 8'h1F, 2);
        5: return e(1, 8'h03, 8'h20, 0);
        6: return e(1, 8'h04, 8'hFF, 28);
        7: return e(1, 8'hE8, 8'hFF, 8'hFC);
        8: return e(1, 8'hEB, 8'h05, 8'h00);
        9: return e(3, 0, 0, 0);
        10: return e(1, 8'hE0, 8'h04, 8'h00);
        11: return e(2, 0, 0, 0);
        12: return e(1, 8'hE0, 8'h04, 8'h04);
        13: return e(1, 8'hE1, 8'h80, 8'h80);
        14: return e(1, 8'hEB, 8'hF8, 8'hF8);
        default: return e(0, 0, 0, 0);
      endcase
    end else begin
      case (i)
        0: return e(1, 8'h00, 8'h7C, 8'h00);
        1: return e(1, 8'h01, 8'h03, 8'h03);
        2: return e(1, 8'h00, 8'h03, 8'h02);
        3: return e(1, 8'h00, 8'h80, 8'h80);
        4: return e(1, 8'hEB, 8'hF8, 8'h00);
        5: return e(1, 8'hE1, 8'h80, 8'h00);
        6: return e(1, 8'hEB, 8'h05, 8'h05);
        default: return e(0, 0, 0, 0);
      endcase
    end
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, expv);
    end
  endtask

  // pulse a request, wait for done (bounded), return whether done was seen
  task automatic issue(bit on, bit off, logic [1:0] md, output bit seen, output bit e_flag);
    int n;
    mode_sel = md;
    pwr_on_req = on;
    pwr_off_req = off;
    @(negedge clk);
    pwr_on_req = 1'b0;
    pwr_off_req = 1'b0;
    n = 0;
    while (!done && n < 20000) begin
      @(negedge clk);
      n++;
    end
    seen = done;
    e_flag = err;
    check(seen == 1'b1, "R10", "done seen", int'(seen), 1);
  endtask

  task automatic run_seq(int seq, bit off_mid, logic [4:0] pd, logic [8:0] fb);
    bit seen, ef;
    int w, gap, i;
    logic [25:0] s;
    string tg;
    for (int k = 0; k < 256; k++) shadow[k] = mem[k];
    log_n = 0;
    prediv_in = pd;
    fbdiv_in  = fb;
    mode_sel  = (seq == 1) ? 2'd1 : 2'd0;
    pwr_on_req  = (seq != 2);
    pwr_off_req = (seq == 2);
    @(negedge clk);
    pwr_on_req = 1'b0;
    pwr_off_req = 1'b0;
    prediv_in = 5'(~pd);
    fbdiv_in  = 9'(~fb);
    @(negedge clk);
    check(busy == 1'b1, "R10", "busy after accept", int'(busy), 1);
    if (off_mid) begin
      // requests during busy must be ignored
      pwr_off_req = 1'b1;
      pwr_on_req  = 1'b1;
      mode_sel    = 2'd1;
      @(negedge clk);
      pwr_off_req = 1'b0;
      pwr_on_req  = 1'b0;
    end
    i = 0;
    while (!done && i < 20000) begin
      @(negedge clk);
      i++;
    end
    check(done == 1'b1, "R10", "done seen", int'(done), 1);
    check(busy == 1'b0 && err == 1'b0, "R10", "busy/err at done", int'({busy, err}), 0);
    @(negedge clk);
    check(done == 1'b0, "R10", "done single cycle", int'(done), 0);
    w = 0;
    for (int j = 0; j < 20; j++) begin
      s = exp_step(seq, j, pd, fb);
      tg = (seq == 2) ? "R8" : (j < 2) ? "R3" : (seq == 0) ? "R4" : "R6";
      if (s[25:24] == 2'd0) break;
      if (s[25:24] == 2'd1) begin
        int a, m, d, nv;
        a = int'(s[23:16]); m = int'(s[15:8]); d = int'(s[7:0]);
        nv = int'((shadow[a] & ~8'(m)) | (8'(d) & 8'(m)));
        shadow[a] = 8'(nv);
        if (w < log_n) begin
          check(log_addr[w] == a, tg, $sformatf("step %0d address", j), log_addr[w], a);
          check(log_val[w] == nv, tg, $sformatf("step %0d R2 masked value", j), log_val[w], nv);
        end
        w++;
      end else if (w > 0 && w < log_n) begin
        gap = log_tick[w] - log_tick[w-1];
        if (s[25:24] == 2'd2)
          check(gap >= RST_US, "R5", "reset pulse ticks", gap, RST_US);
        else
          check(gap >= SET_US, "R7", "settle ticks", gap, SET_US);
      end
    end
    check(log_n == w, tg, "write count", log_n, w);
    begin
      int bad = 0;
      for (int k = 0; k < 256; k++) if (mem[k] !== shadow[k]) bad++;
      check(bad == 0, "R2", "untouched bits and registers", bad, 0);
    end
    if (seq == 0 && log_n > 2)
      check(log_raw[2] == 10'h38C, "R1", "byte address of LVDS offset 3", log_raw[2], 10'h38C);
  endtask

  initial begin
    bit seen, ef;
    void'($urandom(32'h1F2E3D4C));
    for (int k = 0; k < 256; k++) mem[k] = 8'($urandom);
    rst = 1'b1;
    mode_sel = 2'd0;
    pwr_on_req = 1'b0;
    pwr_off_req = 1'b0;
    prediv_in = '0;
    fbdiv_in = '0;
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0 && bus_req == 0 && err == 0, "R10", "reset state",
          int'({busy, done, bus_req, err}), 0);
    rst = 1'b0;
    @(negedge clk);

    // directed corners: smallest and largest divider values
    run_seq(0, 1'b0, 5'd1, 9'd12);
    run_seq(0, 1'b1, 5'd31, 9'd511);
    for (int r = 0; r < 3; r++)
      run_seq(0, 1'b0, 5'($urandom), 9'($urandom));
    run_seq(1, 1'b0, 5'($urandom), 9'($urandom));
    run_seq(2, 1'b0, 5'd0, 9'd0);
    run_seq(1, 1'b1, 5'($urandom), 9'($urandom));
    run_seq(2, 1'b1, 5'd0, 9'd0);

    // R9: unsupported modes
    for (int md = 2; md < 4; md++) begin
      log_n = 0;
      issue(1'b1, 1'b0, 2'(md), seen, ef);
      check(ef == 1'b1, "R9", "err flag", int'(ef), 1);
      repeat (10) @(negedge clk);
      check(log_n == 0 && busy == 0, "R9", "no bus writes", log_n, 0);
    end
    // R10: simultaneous requests, power-on wins
    log_n = 0;
    issue(1'b1, 1'b1, 2'd0, seen, ef);
    check(log_n == 14 - 2, "R10", "on wins over off (serial write count)", log_n, 12);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule